// File: doc/BRIEF.md
# Polyphase FIR interpolator

This block raises the sample rate of a stream of signed fixed-point samples by an integer factor `L`. Its output matches what you would get by placing `L-1` zero samples after every input sample and then running the longer stream through a prototype FIR filter `g[m]` of `L*TPP` taps. The block never multiplies by those zeros. Instead it splits the prototype into `L` short sub-filters. Each sub-filter has `TPP` taps and works on the same history of the last `TPP` input samples. The sub-filters take turns: one output sample comes from each of them, in order.

Samples enter through a valid/ready handshake at the low rate. Output samples leave as a valid-qualified stream, at most one per clock, so each input sample produces a burst of `L` outputs. The block accepts the next input during the clock in which the last output of the current burst is computed. A source that always has data ready therefore gets a continuous output stream with no gaps.

The prototype coefficients are set through a parameter. Each product is summed at full precision. After that, one rounding step and one saturation step produce the output word.

Top module: `poly_interp`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears the stored input history. After that edge `out_valid` is low and `in_ready` is high. The first outputs after reset therefore depend only on inputs accepted after reset.
- R2: An input is accepted at a rising edge where `in_valid` and `in_ready` are both high. That acceptance produces exactly `L` output samples with `out_valid` high. They appear after the edges 1 through `L` that follow the acceptance, in phase order k = 0 to `L-1`. `out_valid` is low in every other cycle.
- R3: Let n count accepted inputs. Output sample k of input n equals Q(sum over j of g[k+jL]·x[n-j]) for j = 0..TPP-1, with x taken as zero before reset. This is bit-identical to the zero-stuffed direct-form filter.
- R4: The rounding Q adds 2^(SHIFT-1) to the full-precision sum and then shifts it arithmetically right by SHIFT bits. Halfway cases therefore round toward plus infinity.
- R5: After rounding, a value above 2^(DW-1)-1 becomes 2^(DW-1)-1, and a value below -2^(DW-1) becomes -2^(DW-1).
- R6: `in_ready` is high when no burst is in progress, or when the last output of the current burst is being computed. It is low otherwise. Back-to-back inputs therefore give an output stream with no gaps.
- R7: `in_valid` and `in_data` have no effect while `in_ready` is low. The data they carry never appears in any later output.
- R8: Prototype tap m is the signed `CW`-bit field at bits [m·CW +: CW] of `COEFS`. Sub-filter k uses the taps g[k], g[k+L], g[k+2L] and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take an input this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_data | output | DW | Signed rounded and saturated output sample |

## Verification
A phase counter that slips shows up on the very next output. That output then carries the taps of the wrong sub-filter, or `out_valid` and `in_ready` leave the required burst pattern. A wrong history word is harder to see at the ports. It corrupts outputs only until it is shifted out, which takes up to `TPP` accepted inputs, or `TPP*L` output cycles. For that reason the bench compares every output cycle against a zero-stuffed direct-form model, using impulses, inputs with only the LSB set, and full-scale inputs. A fault is reported within one output cycle of the first sample it corrupts.

// File: rtl/poly_interp_pkg.sv
package poly_interp_pkg;

  typedef enum logic {
    PI_IDLE = 1'b0,
    PI_RUN  = 1'b1
  } pi_state_e;

  // index width that stays at least one bit for tiny counts
  function automatic int pi_bits(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/pi_history.sv
module pi_history #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic [DW-1:0]       din,
  output logic [DEPTH*DW-1:0] hist_flat
);

  logic [DW-1:0] taps_q [DEPTH];

  generate
    for (genvar j = 0; j < DEPTH; j++) begin : g_tap
      if (j == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst)           taps_q[j] <= '0;
          else if (shift_en) taps_q[j] <= din;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst)           taps_q[j] <= '0;
          else if (shift_en) taps_q[j] <= taps_q[j-1];
        end
      end
      assign hist_flat[j*DW +: DW] = taps_q[j];
    end
  endgenerate

  // R1: reset empties the oldest slot as well as the newest
  a_r1_hist_cleared: assert property (@(posedge clk)
    rst |=> (taps_q[DEPTH-1] == '0 && taps_q[0] == '0));

  // R7: nothing enters the history unless a sample was accepted
  a_r7_hist_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(taps_q[0]));

  // R3: the accepted sample becomes the newest history entry
  a_r3_hist_load: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (taps_q[0] == $past(din)));

endmodule

// File: rtl/pi_phase_ctrl.sv
module pi_phase_ctrl
  import poly_interp_pkg::*;
#(
  parameter int L   = 4,
  parameter int PHW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  output logic           accept,
  output logic           busy,
  output logic [PHW-1:0] phase
);

  pi_state_e      state_q;
  logic [PHW-1:0] phase_q;
  logic           last;

  assign busy     = (state_q == PI_RUN);
  assign last     = busy && (phase_q == PHW'(L-1));
  assign in_ready = !busy || last;
  assign accept   = in_valid && in_ready;
  assign phase    = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PI_IDLE;
      phase_q <= '0;
    end else if (accept) begin
      state_q <= PI_RUN;
      phase_q <= '0;
    end else if (last) begin
      state_q <= PI_IDLE;
      phase_q <= '0;
    end else if (busy) begin
      phase_q <= phase_q + PHW'(1);
    end
  end

  // R2: an accepted sample always starts at branch zero
  a_r2_burst_start: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && phase == '0));

  // R2: branches advance one per cycle inside a burst
  a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
    (busy && !last && !accept) |=> (busy && phase == $past(phase) + PHW'(1)));

  // R2: a burst with no follow-on sample ends after the last branch
  a_r2_burst_end: assert property (@(posedge clk) disable iff (rst)
    (last && !in_valid) |=> !busy);

endmodule

// File: rtl/pi_branch_mac.sv
module pi_branch_mac #(
  parameter int                   L     = 4,
  parameter int                   TPP   = 4,
  parameter int                   DW    = 16,
  parameter int                   CW    = 16,
  parameter int                   PHW   = 2,
  parameter int                   AW    = 35,
  parameter logic [L*TPP*CW-1:0]  COEFS = '0
) (
  input  logic [PHW-1:0]        phase,
  input  logic [TPP*DW-1:0]     hist_flat,
  output logic signed [AW-1:0]  acc
);

  localparam int PW = DW + CW;

  logic signed [CW-1:0] ctab [L][TPP];

  // branch k, tap j picks prototype tap k + j*L
  generate
    for (genvar k = 0; k < L; k++) begin : g_branch
      for (genvar j = 0; j < TPP; j++) begin : g_tap
        assign ctab[k][j] = COEFS[(k + j*L)*CW +: CW];
      end
    end
  endgenerate

  logic signed [PW-1:0] prod [TPP];

  always_comb begin
    acc = '0;
    for (int j = 0; j < TPP; j++) begin
      prod[j] = $signed(hist_flat[j*DW +: DW]) * ctab[phase][j];
      acc     = acc + {{(AW-PW){prod[j][PW-1]}}, prod[j]};
    end
  end

endmodule

// File: rtl/pi_round_sat.sv
module pi_round_sat #(
  parameter int AW    = 35,
  parameter int DW    = 16,
  parameter int SHIFT = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_i,
  input  logic signed [AW-1:0] acc_i,
  output logic                valid_o,
  output logic [DW-1:0]       data_o
);

  localparam int RW = AW + 1;
  localparam logic signed [RW-1:0] MAXV = {{(RW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [RW-1:0] MINV = {{(RW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] TOPV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] BOTV = {1'b1, {(DW-1){1'b0}}};

  logic signed [RW-1:0] ext;
  logic signed [RW-1:0] rnd;
  logic [DW-1:0]        sat;

  assign ext = {acc_i[AW-1], acc_i};

  generate
    if (SHIFT > 0) begin : g_round
      localparam logic signed [RW-1:0] HALF = RW'(1) <<< (SHIFT-1);
      assign rnd = (ext + HALF) >>> SHIFT;
    end else begin : g_pass
      assign rnd = ext;
    end
  endgenerate

  always_comb begin
    if (rnd > MAXV)      sat = TOPV;
    else if (rnd < MINV) sat = BOTV;
    else                 sat = rnd[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= sat;
    end
  end

  // R1: output stream is silent right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> !valid_o);

  // R5: positive overflow clamps to the largest code
  a_r5_clamp_high: assert property (@(posedge clk) disable iff (rst)
    (valid_i && rnd > MAXV) |=> (data_o == TOPV));

  // R5: negative overflow clamps to the smallest code
  a_r5_clamp_low: assert property (@(posedge clk) disable iff (rst)
    (valid_i && rnd < MINV) |=> (data_o == BOTV));

endmodule

// File: rtl/poly_interp.sv
module poly_interp
  import poly_interp_pkg::*;
#(
  parameter int                  L     = 4,
  parameter int                  TPP   = 4,
  parameter int                  DW    = 16,
  parameter int                  CW    = 16,
  parameter int                  SHIFT = CW - 1,
  parameter logic [L*TPP*CW-1:0] COEFS = {
    16'sd900,   -16'sd700,  16'sd500,   -16'sd300,
    16'sd26000, -16'sd6000, 16'sd10000, 16'sd16384,
    16'sd24000, 16'sd22000, 16'sd18000, 16'sd16384,
    -16'sd3000, 16'sd2500,  -16'sd1500, 16'sd800 }
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  localparam int PHW = pi_bits(L);
  localparam int AW  = DW + CW + $clog2(TPP) + 1;

  logic                accept;
  logic                busy;
  logic [PHW-1:0]      phase;
  logic [TPP*DW-1:0]   hist_flat;
  logic signed [AW-1:0] acc;

  pi_phase_ctrl #(.L(L), .PHW(PHW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .busy     (busy),
    .phase    (phase)
  );

  pi_history #(.DW(DW), .DEPTH(TPP)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (accept),
    .din       (in_data),
    .hist_flat (hist_flat)
  );

  pi_branch_mac #(
    .L(L), .TPP(TPP), .DW(DW), .CW(CW), .PHW(PHW), .AW(AW), .COEFS(COEFS)
  ) u_mac (
    .phase     (phase),
    .hist_flat (hist_flat),
    .acc       (acc)
  );

  pi_round_sat #(.AW(AW), .DW(DW), .SHIFT(SHIFT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .valid_i (busy),
    .acc_i   (acc),
    .valid_o (out_valid),
    .data_o  (out_data)
  );

  // R2: every branch computed in a burst reaches the output next cycle
  a_r2_burst_emits: assert property (@(posedge clk) disable iff (rst)
    busy |=> out_valid);

  // R2: no output appears outside a burst
  a_r2_no_stray_output: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !out_valid);

  // R6: an idle block never refuses a sample
  a_r6_idle_ready: assert property (@(posedge clk) disable iff (rst)
    !busy |-> in_ready);

endmodule

// File: tb/poly_interp_test.sv
module poly_interp_test;

  localparam int L   = 4;
  localparam int TPP = 4;
  localparam int N   = L * TPP;
  localparam int DW  = 16;
  localparam int CW  = 16;
  localparam int SH  = 15;
  // tap m at bits [m*CW +: CW] (R8); listed from m=15 down to m=0
  localparam logic [N*CW-1:0] COEFS = {
    16'sd1100,  -16'sd900,  16'sd700,   -16'sd500,
    16'sd30000, -16'sd8000, 16'sd12000, 16'sd16384,
    16'sd28000, 16'sd24000, 16'sd20000, 16'sd16384,
    -16'sd4000, 16'sd3000,  -16'sd2000, 16'sd1000 };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic          out_valid;
  logic [DW-1:0] out_data;

  poly_interp #(.L(L), .TPP(TPP), .DW(DW), .CW(CW), .SHIFT(SH), .COEFS(COEFS)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  int     passed = 0;
  int     total  = 0;
  bit     done   = 0;
  int     cyc    = 0;
  string  cur    = "R3";
  longint g [N];
  longint ustream [N];
  longint exp_val [$];
  int     exp_due [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (ok) passed++;
    else $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, expv, $time);
  endtask

  function automatic longint quant(input longint acc);
    longint r;
    r = (SH > 0) ? ((acc + (64'sd1 <<< (SH-1))) >>> SH) : acc;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  // direct form on the zero-stuffed stream
  task automatic model_accept(input longint x);
    longint acc;
    for (int k = 0; k < L; k++) begin
      for (int i = N-1; i > 0; i--) ustream[i] = ustream[i-1];
      ustream[0] = (k == 0) ? x : 0;
      acc = 0;
      for (int i = 0; i < N; i++) acc += g[i] * ustream[i];
      exp_val.push_back(quant(acc));
      exp_due.push_back(cyc + 2 + k);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) ustream[i] = 0;
    exp_val.delete();
    exp_due.delete();
  endtask

  task automatic step(input bit v, input logic [DW-1:0] x, output bit took);
    int pending;
    longint ev;
    string tag;
    @(negedge clk);
    cyc++;
    if (exp_due.size() > 0 && exp_due[0] == cyc) begin
      ev = exp_val.pop_front();
      void'(exp_due.pop_front());
      chk(out_valid === 1'b1, "R2", "out_valid in burst", out_valid, 1);
      tag = (ev == 32767 || ev == -32768) ? "R5" : cur;
      chk($signed(out_data) == ev, tag, "out_data", $signed(out_data), ev);
    end else begin
      chk(out_valid === 1'b0, "R2", "out_valid outside burst", out_valid, 0);
    end
    pending = 0;
    foreach (exp_due[i]) if (exp_due[i] > cyc) pending++;
    chk(in_ready === (pending <= 1), "R6", "in_ready", in_ready, pending <= 1);
    in_valid = v;
    // R7: data offered while not ready is junk and must never be used
    in_data  = in_ready ? x : DW'($urandom);
    took     = v && in_ready;
    if (took) model_accept($signed(x));
  endtask

  task automatic send(input logic [DW-1:0] x);
    bit took;
    do step(1'b1, x, took); while (!took);
  endtask

  task automatic idle(input int n);
    bit took;
    for (int i = 0; i < n; i++) step(1'b0, '0, took);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready === 1'b1, "R1", "in_ready in reset", in_ready, 1);
    rst = 1'b0;
    cyc += 3;
    model_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R2", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < N; m++) g[m] = $signed(COEFS[m*CW +: CW]);
    rst = 1'b1;
    in_valid = 1'b0;
    in_data = '0;
    model_clear();
    do_reset();

    // R8: impulse of -32768 reproduces every tap negated, branch by branch
    cur = "R8";
    send(16'h8000);
    idle(L + 2);
    for (int i = 0; i < TPP; i++) send(16'h0000);
    idle(L + 2);

    // R4: LSB impulse exercises half-way rounding (16384/32768 -> 1)
    cur = "R4";
    send(16'h0001);
    for (int i = 0; i < TPP; i++) send(16'h0000);
    send(16'hFFFF);
    for (int i = 0; i < TPP; i++) send(16'h0000);
    idle(L + 2);

    // R3: back-to-back random stream
    cur = "R3";
    for (int i = 0; i < 40; i++) send(DW'($urandom));
    idle(L + 2);

    // R3: random stream with idle gaps
    for (int i = 0; i < 30; i++) begin
      send(DW'($urandom));
      idle($urandom_range(0, 5));
    end
    idle(L + 2);

    // R7: valid held high with junk data while not ready
    cur = "R7";
    for (int i = 0; i < 20; i++) send(DW'($urandom_range(0, 4000)));
    idle(L + 2);

    // R5: full-scale patterns push branches past the output range
    cur = "R5";
    for (int i = 0; i < 12; i++) send(16'h7FFF);
    for (int i = 0; i < 12; i++) send(16'h8000);
    for (int i = 0; i < 12; i++) send((i % 2 == 0) ? 16'h7FFF : 16'h8000);
    idle(L + 2);

    // R1: reset in mid burst, then history must read as zeros
    cur = "R1";
    send(16'h7000);
    send(16'h9000);
    do_reset();
    send(16'h4000);
    for (int i = 0; i < TPP; i++) send(16'h0000);
    idle(L + 4);
    chk(exp_val.size() == 0, "R2", "outputs still owed", exp_val.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

endmodule